// File: doc/BRIEF.md
# Architectural Register File

This block holds the complete architectural register state of a 64-bit processor core: 64 registers, each 64 bits wide, each selected by a 6-bit index. Operand logic reads two registers at once through combinational read ports. It writes one register per cycle through a general write port. The fetch and control logic have their own side ports for the instruction pointer and the flags register. These side ports can update those two registers in the same cycle as an operand write to some other register.

Some indices are fixed in meaning. Index 0 is the instruction pointer, 1 the stack pointer, 2 the frame pointer, 3 the flags register and 13 the status register. Indices 14 to 63 are the general registers. Indices 4 to 12 are a reserved gap that holds no state. In the flags register, bit 0 (counted from the least significant end) is the halt flag and bit 1 is the compare flag.

The block decodes a two-state run status from the halt flag: ACTIVE when bit 0 is clear and HALTED when it is set. There are no transition events beyond the halt bit itself. ACTIVE goes to HALTED whenever any write sets flag bit 0. HALTED goes back to ACTIVE whenever a write or a reset clears it. The `halted` output reports the HALTED state, and the machine stops executing while it is 1.

Top module: `arch_regfile`

## Requirements
- R1: When `wr_en` is 1 and `wr_idx` is outside 4..12, `wr_data` is stored at `wr_idx` on the rising clock edge. From the next cycle both read ports return it for that index. This holds for indices 0..3 and 13..63, including stack pointer 1, frame pointer 2, status 13 and general registers 14..63.
- R2: Indices 4 to 12 always read as zero on both read ports. General writes to them change nothing.
- R3: Each read port returns the contents of the register at `rd_a_idx` / `rd_b_idx` combinationally, as they were before the edge. A write to the same index in the same cycle is not forwarded.
- R4: When `pc_wr_en` is 1, `pc_wr_data` is stored in index 0 at the edge. `pc_q` always equals the contents of index 0.
- R5: When `flg_wr_en` is 1, `flg_wr_data` is stored in index 3 at the edge. `flg_q` always equals the contents of index 3.
- R6: If a general write targets index 0 or 3 in the same cycle as the matching side-port write, the general write's data is stored. A side-port write and a general write to a different index both take effect.
- R7: `halted` is 1 exactly when bit 0 of the flags register is 1. It changes in the same cycle as the flags register, and bit 1 (compare) has no effect on it.
- R8: While `rst_n` is low, every register is zero, `pc_q` and `flg_q` are 0 and `halted` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 6 | Read port A register index |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 6 | Read port B register index |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 6 | General write register index |
| wr_data | input | 64 | General write data |
| pc_wr_en | input | 1 | Instruction pointer side-port write enable |
| pc_wr_data | input | 64 | Instruction pointer side-port data |
| pc_q | output | 64 | Current instruction pointer (index 0) |
| flg_wr_en | input | 1 | Flags side-port write enable |
| flg_wr_data | input | 64 | Flags side-port data |
| flg_q | output | 64 | Current flags register (index 3) |
| halted | output | 1 | Run status is HALTED (flag bit 0 set) |

## Verification
Read data, `pc_q`, `flg_q` and `halted` are combinational functions of the indices and the stored state, so they are due in the same cycle as the index change. Writes from any port are due one rising edge after they are presented. The bench drives all inputs just after the falling edge and compares every output one nanosecond later. It updates its behavioural register model only after the following rising edge, so a same-cycle read of a register being written must still show the old value. Collision cycles and halt-flag cycles are compared on the cycle after the edge, which is when the new register contents become visible.

// File: rtl/arch_rf_pkg.sv
package arch_rf_pkg;

    // Fixed register roles whose positions the datapath relies on
    localparam int unsigned IDX_PC  = 0;
    localparam int unsigned IDX_FLG = 3;

    // Reserved gap that holds no state
    localparam int unsigned GAP_LO = 4;
    localparam int unsigned GAP_HI = 12;

    // Flag bit positions, counted from the least significant end
    localparam int unsigned FLG_HALT_BIT = 0;

    typedef enum logic {
        RUN_ACTIVE = 1'b0,
        RUN_HALTED = 1'b1
    } run_state_e;

    function automatic logic in_gap(input int unsigned idx);
        return (idx >= GAP_LO) && (idx <= GAP_HI);
    endfunction

endpackage

// File: rtl/rf_wr_sel.sv
module rf_wr_sel
    import arch_rf_pkg::*;
#(
    parameter int unsigned NREG = 64,
    parameter int unsigned DW   = 64,
    parameter int unsigned IW   = 6
) (
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     pc_wr_en,
    input  logic [DW-1:0]            pc_wr_data,
    input  logic                     flg_wr_en,
    input  logic [DW-1:0]            flg_wr_data,
    output logic [NREG-1:0]          reg_en,
    output logic [NREG-1:0][DW-1:0]  reg_d
);

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        localparam bit IS_GAP = in_gap(g);
        localparam bit IS_PC  = (g == IDX_PC);
        localparam bit IS_FLG = (g == IDX_FLG);

        logic          hit_gen;
        logic          hit_side;
        logic [DW-1:0] side_d;

        // General port: only real registers accept it
        if (IS_GAP) begin : g_gap
            assign hit_gen = 1'b0;
        end else begin : g_real
            assign hit_gen = wr_en && (wr_idx == IW'(g));
        end

        // Side ports exist only for the instruction pointer and flags
        if (IS_PC) begin : g_pc
            assign hit_side = pc_wr_en;
            assign side_d   = pc_wr_data;
        end else if (IS_FLG) begin : g_flg
            assign hit_side = flg_wr_en;
            assign side_d   = flg_wr_data;
        end else begin : g_none
            assign hit_side = 1'b0;
            assign side_d   = '0;
        end

        // General write has priority over a side-port write
        assign reg_en[g] = hit_gen | hit_side;
        assign reg_d[g]  = hit_gen ? wr_data : side_d;
    end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int unsigned NREG = 64,
    parameter int unsigned DW   = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          reg_en,
    input  logic [NREG-1:0][DW-1:0]  reg_d,
    output logic [NREG-1:0][DW-1:0]  reg_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q[g] <= '0;
            end else if (reg_en[g]) begin
                reg_q[g] <= reg_d[g];
            end
        end
    end

endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
    parameter int unsigned NREG = 64,
    parameter int unsigned DW   = 64,
    parameter int unsigned IW   = 6
) (
    input  logic [NREG-1:0][DW-1:0]  reg_q,
    input  logic [IW-1:0]            idx,
    output logic [DW-1:0]            data
);

    always_comb begin
        data = reg_q[idx];
    end

endmodule

// File: rtl/arch_regfile.sv
module arch_regfile
    import arch_rf_pkg::*;
#(
    parameter int unsigned NREG = 64,
    parameter int unsigned DW   = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREG)-1:0]  rd_a_idx,
    output logic [DW-1:0]            rd_a_data,
    input  logic [$clog2(NREG)-1:0]  rd_b_idx,
    output logic [DW-1:0]            rd_b_data,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     pc_wr_en,
    input  logic [DW-1:0]            pc_wr_data,
    output logic [DW-1:0]            pc_q,
    input  logic                     flg_wr_en,
    input  logic [DW-1:0]            flg_wr_data,
    output logic [DW-1:0]            flg_q,
    output logic                     halted
);

    localparam int unsigned IW = $clog2(NREG);

    logic [NREG-1:0]         reg_en;
    logic [NREG-1:0][DW-1:0] reg_d;
    logic [NREG-1:0][DW-1:0] reg_q;
    run_state_e              run_state;

    rf_wr_sel #(.NREG(NREG), .DW(DW), .IW(IW)) u_wr_sel (
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .pc_wr_en    (pc_wr_en),
        .pc_wr_data  (pc_wr_data),
        .flg_wr_en   (flg_wr_en),
        .flg_wr_data (flg_wr_data),
        .reg_en      (reg_en),
        .reg_d       (reg_d)
    );

    rf_bank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .reg_en (reg_en),
        .reg_d  (reg_d),
        .reg_q  (reg_q)
    );

    rf_rd_mux #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd_a (
        .reg_q (reg_q),
        .idx   (rd_a_idx),
        .data  (rd_a_data)
    );

    rf_rd_mux #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd_b (
        .reg_q (reg_q),
        .idx   (rd_b_idx),
        .data  (rd_b_data)
    );

    assign pc_q  = reg_q[IDX_PC];
    assign flg_q = reg_q[IDX_FLG];

    // Run status: the state lives in the halt bit of the flags register
    always_comb begin
        run_state = flg_q[FLG_HALT_BIT] ? RUN_HALTED : RUN_ACTIVE;
    end

    always_comb begin
        unique case (run_state)
            RUN_ACTIVE: halted = 1'b0;
            RUN_HALTED: halted = 1'b1;
            default:    halted = 1'b0;
        endcase
    end

endmodule

// File: rtl/arch_regfile_chk.sv
module arch_regfile_chk
    import arch_rf_pkg::*;
#(
    parameter int unsigned NREG = 64,
    parameter int unsigned DW   = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREG)-1:0]  rd_a_idx,
    input  logic [DW-1:0]            rd_a_data,
    input  logic [$clog2(NREG)-1:0]  rd_b_idx,
    input  logic [DW-1:0]            rd_b_data,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     pc_wr_en,
    input  logic [DW-1:0]            pc_wr_data,
    input  logic [DW-1:0]            pc_q,
    input  logic                     flg_wr_en,
    input  logic [DW-1:0]            flg_wr_data,
    input  logic [DW-1:0]            flg_q,
    input  logic                     halted
);

    localparam int unsigned IW = $clog2(NREG);

    // R8: everything reads as cleared while reset is held
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (pc_q == '0) && (flg_q == '0) && !halted);

    // R1: a general write to a real register is readable after the edge
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_gap(32'(wr_idx)))
        |=> (rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data)));

    // R2: the reserved gap reads as zero
    a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap(32'(rd_b_idx)) |-> (rd_b_data == '0));

    // R4: side port loads the instruction pointer when not overridden
    a_r4_pc_side: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_en && !(wr_en && (wr_idx == IW'(IDX_PC))))
        |=> (pc_q == $past(pc_wr_data)));

    // R4: dedicated output agrees with an operand read of index 0
    a_r4_pc_port_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == IW'(IDX_PC)) |-> (rd_a_data == pc_q));

    // R5: side port loads the flags when not overridden
    a_r5_flg_side: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_wr_en && !(wr_en && (wr_idx == IW'(IDX_FLG))))
        |=> (flg_q == $past(flg_wr_data)));

    // R6: general write wins over the instruction pointer side port
    a_r6_gen_wins_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IW'(IDX_PC)) && pc_wr_en)
        |=> (pc_q == $past(wr_data)));

    // R7: a general write to flags sets the halt output from its bit 0
    a_r7_halt_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IW'(IDX_FLG)))
        |=> (halted == $past(wr_data[FLG_HALT_BIT])));

endmodule

bind arch_regfile arch_regfile_chk #(.NREG(NREG), .DW(DW)) u_chk (.*);

// File: tb/arch_regfile_test.sv
`timescale 1ns/1ps
module arch_regfile_test;

    localparam int NREG = 64;
    localparam int DW   = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [5:0]    rd_a_idx, rd_b_idx, wr_idx;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
    logic [DW-1:0] pc_wr_data, pc_q, flg_wr_data, flg_q;
    logic          wr_en, pc_wr_en, flg_wr_en, halted;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    logic [DW-1:0] mdl [NREG];

    always #4 clk = ~clk;  // 125 MHz

    arch_regfile #(.NREG(NREG), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .pc_q(pc_q),
        .flg_wr_en(flg_wr_en), .flg_wr_data(flg_wr_data), .flg_q(flg_q),
        .halted(halted)
    );

    function automatic bit gap(input int idx);
        return idx >= 4 && idx <= 12;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL [%s] %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input bit we, input int wi, input logic [DW-1:0] wd,
                         input bit pe, input logic [DW-1:0] pd,
                         input bit fe, input logic [DW-1:0] fd,
                         input int ra, input int rb);
        wr_en = we; wr_idx = 6'(wi); wr_data = wd;
        pc_wr_en = pe; pc_wr_data = pd;
        flg_wr_en = fe; flg_wr_data = fd;
        rd_a_idx = 6'(ra); rd_b_idx = 6'(rb);
    endtask

    // Compare outputs mid-cycle, then advance the model past the edge
    task automatic tick(input string tag);
        #1;
        check(tag, gap(int'(rd_a_idx)) ? "rd_a_data R2" : "rd_a_data R1/R3",
              rd_a_data, mdl[rd_a_idx]);
        check(tag, gap(int'(rd_b_idx)) ? "rd_b_data R2" : "rd_b_data R1/R3",
              rd_b_data, mdl[rd_b_idx]);
        check(tag, "pc_q R4", pc_q, mdl[0]);
        check(tag, "flg_q R5", flg_q, mdl[3]);
        check(tag, "halted R7", {63'd0, halted}, {63'd0, mdl[3][0]});
        @(posedge clk);
        if (rst_n) begin
            if (pc_wr_en)  mdl[0] = pc_wr_data;
            if (flg_wr_en) mdl[3] = flg_wr_data;
            if (wr_en && !gap(int'(wr_idx))) mdl[wr_idx] = wr_data;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            mismatched++;
            $display("FAIL [watchdog] run did not finish act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        rst_n = 1'b0;
        drive(0, 0, '0, 0, '0, 0, '0, 0, 3);
        @(negedge clk);
        // R8: cleared while reset is held, inputs ignored
        drive(1, 20, 64'hFFFF, 1, 64'h1234, 1, 64'h1, 0, 3);
        tick("R8");
        drive(0, 0, '0, 0, '0, 0, '0, 20, 13);
        tick("R8");
        rst_n = 1'b1;

        // R8: every register zero after reset
        for (int i = 0; i < NREG; i++) begin
            drive(0, 0, '0, 0, '0, 0, '0, i, NREG - 1 - i);
            tick("R8");
        end

        // R1/R2/R3: write each index, read same index in the same cycle
        for (int i = 0; i < NREG; i++) begin
            logic [DW-1:0] pat;
            pat = 64'hA5C3_0000_0000_0000 ^ (64'(i) * 64'h0001_0203_0405_0607);
            if (i == 3) pat = 64'h0000_0000_0000_0002;  // keep halt clear
            drive(1, i, pat, 0, '0, 0, '0, i, (i + NREG - 1) % NREG);
            tick("R3");
        end
        for (int i = 0; i < NREG; i++) begin
            drive(0, 0, '0, 0, '0, 0, '0, i, (i * 7) % NREG);
            tick(gap(i) ? "R2" : "R1");
        end

        // R4: instruction pointer side port
        drive(0, 0, '0, 1, 64'h0000_0000_0000_4000, 0, '0, 0, 1);
        tick("R4");
        drive(0, 0, '0, 0, '0, 0, '0, 0, 2);
        tick("R4");

        // R5/R7: compare bit alone does not halt; halt bit does
        drive(0, 0, '0, 0, '0, 1, 64'h2, 3, 0);
        tick("R5");
        drive(0, 0, '0, 0, '0, 1, 64'h3, 3, 0);
        tick("R7");
        drive(1, 3, 64'h0, 0, '0, 0, '0, 3, 13);
        tick("R7");
        drive(0, 0, '0, 0, '0, 0, '0, 3, 13);
        tick("R7");

        // R6: collisions on index 0 and 3, and a non-colliding pair
        drive(1, 0, 64'hDEAD_0000_0000_0001, 1, 64'h0BAD_0000_0000_0000, 0, '0, 0, 3);
        tick("R6");
        drive(1, 3, 64'h1, 0, '0, 1, 64'h0, 0, 3);
        tick("R6");
        drive(1, 20, 64'h7777_0000_0000_0020, 1, 64'h8000, 1, 64'h0, 20, 0);
        tick("R6");
        drive(0, 0, '0, 0, '0, 0, '0, 20, 3);
        tick("R6");

        // R1..R7: mixed traffic including gap writes and collisions
        for (int n = 0; n < 4000; n++) begin
            drive($urandom_range(0, 1) == 1, $urandom_range(0, 63), {$urandom, $urandom},
                  $urandom_range(0, 3) == 0, {$urandom, $urandom},
                  $urandom_range(0, 3) == 0, {62'd0, 2'($urandom)},
                  $urandom_range(0, 63), $urandom_range(0, 63));
            tick("R1");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule